// File: doc/BRIEF.md
# Flash Protected Range Checker

This block guards a serial flash against forbidden accesses. It holds five 32-bit range registers. Each one describes a window of flash address space at 4 KiB page granularity and has its own enables for blocking writes and blocking reads. Write blocking also covers erase, because an erase is a write-direction access. Software programs the range registers first. It then sets a lock-down bit, and from that point the ranges are enforced and cannot be changed until reset.

Each flash access request is presented as one qualified cycle carrying an address and a direction flag. The checker compares the request against every range whose enable matches the direction. On the following clock edge it gives one of two results. A permitted access gets a single-cycle start pulse for the flash cycle. A blocked access gets a single-cycle error pulse and no start. A level output keeps the verdict of the most recent request. While the lock-down bit is clear, no request is ever blocked.

Top module: `prr_checker`

## Requirements
- R1: After reset all five range registers read back as zero, the lock is clear, and acc_blocked, acc_err and acc_go are low.
- R2: A register write (cfg_we high, cfg_idx 0..4, lock clear) stores cfg_wdata with bits 30:29 and 14:13 forced to zero. The stored value is visible combinationally on rd_data when rd_idx selects that register.
- R3: A register write with cfg_idx 5 or above changes no register. Reading rd_idx 5 or above returns zero.
- R4: lock_set sets the lock, which stays set until reset. While the lock is set, register writes are ignored.
- R5: While the lock is clear, every request is permitted. acc_go pulses in the cycle after it and acc_err stays low.
- R6: Register layout: bit 31 enables write blocking, bit 15 enables read blocking, bits 28:16 hold the upper page and bits 12:0 hold the lower page. The page is request address bits 24:12. The window runs from lower page offset 0x000 through upper page offset 0xFFF, with both ends inclusive.
- R7: With the lock set, a write request (acc_write=1, used for program and erase) is blocked when its page falls in any range with bit 31 set. A read request (acc_write=0) is blocked when its page falls in any range with bit 15 set.
- R8: A range with only the read enable does not block writes, and a range with only the write enable does not block reads. A range with neither enable blocks nothing.
- R9: One clock after a request, a blocked request gives acc_err high for exactly one cycle with acc_go low. A permitted request gives acc_go high for exactly one cycle with acc_err low. acc_blocked holds the verdict of the latest request until the next one.
- R10: A range whose lower page exceeds its upper page covers no address.
- R11: A register write in the same cycle as lock_set still takes effect. The lock applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Register index for a write |
| cfg_wdata | input | 32 | Write data |
| lock_set | input | 1 | Sets the lock-down bit |
| rd_idx | input | 3 | Register index for readback |
| rd_data | output | 32 | Readback value of the selected register |
| locked | output | 1 | Lock-down state |
| acc_valid | input | 1 | Flash access request qualifier |
| acc_addr | input | 25 | Flash byte address of the request |
| acc_write | input | 1 | 1 = write or erase, 0 = read |
| acc_blocked | output | 1 | Verdict of the latest request |
| acc_err | output | 1 | One-cycle pulse for a blocked request |
| acc_go | output | 1 | One-cycle pulse that starts a permitted flash cycle |

## Verification
The assertions assume three things about the inputs:
- acc_valid, acc_addr and acc_write are sampled only at the rising edge and are treated as one request per qualified cycle.
- Reset is asserted from time zero.
- Nothing other than reset may clear the lock.

The stimulus drives every input on the falling edge and keeps each request high for exactly one cycle, returning acc_valid low between requests. Writes with out-of-range indices and writes issued after locking are deliberately included, so the properties on frozen registers and on verdict timing see the ignored paths as well as the normal ones.

// File: rtl/prr_pkg.sv
package prr_pkg;
    localparam int REG_W    = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = 13;
    localparam int ADDR_W   = PAGE_LSB + PAGE_W;
    localparam int WP_BIT   = 31;
    localparam int RP_BIT   = 15;
    localparam int HI_LSB   = 16;
    localparam int LO_LSB   = 0;
    // bits kept on write: 31, 28:16, 15, 12:0
    localparam logic [REG_W-1:0] KEEP_MASK = 32'h9FFF_9FFF;

    typedef struct packed {
        logic              wp;
        logic              rp;
        logic [PAGE_W-1:0] hi;
        logic [PAGE_W-1:0] lo;
    } window_t;

    function automatic window_t decode_window(input logic [REG_W-1:0] r);
        window_t w;
        w.wp = r[WP_BIT];
        w.rp = r[RP_BIT];
        w.hi = r[HI_LSB +: PAGE_W];
        w.lo = r[LO_LSB +: PAGE_W];
        return w;
    endfunction
endpackage

// File: rtl/prr_window.sv
module prr_window
    import prr_pkg::*;
(
    input  window_t           win,
    input  logic [PAGE_W-1:0] page,
    input  logic              is_write,
    output logic              hit
);
    logic inside_win;
    logic dir_on;

    always_comb begin
        inside_win = (page >= win.lo) && (page <= win.hi);
        dir_on     = is_write ? win.wp : win.rp;
        hit        = inside_win && dir_on;
    end
endmodule

// File: rtl/prr_regs.sv
module prr_regs
    import prr_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [IDX_W-1:0]                     cfg_idx,
    input  logic [REG_W-1:0]                     cfg_wdata,
    input  logic                                 lock_set,
    input  logic [IDX_W-1:0]                     rd_idx,
    output logic [REG_W-1:0]                     rd_data,
    output logic [NUM_RANGES-1:0][REG_W-1:0]     regs_o,
    output logic                                 locked_o
);
    typedef struct packed {
        logic                             locked;
        logic [NUM_RANGES-1:0][REG_W-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_we && !st_q.locked && (int'(cfg_idx) == i))
                st_d.regs[i] = cfg_wdata & KEEP_MASK;
        end
        if (lock_set)
            st_d.locked = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (int'(rd_idx) == i) rd_data = st_q.regs[i];
        end
    end

    assign regs_o   = st_q.regs;
    assign locked_o = st_q.locked;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked); // R4
    AST_FROZEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.regs)); // R4

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rsvd
        AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.regs[g] & ~KEEP_MASK) == '0); // R2
    end
endmodule

// File: rtl/prr_checker.sv
module prr_checker
    import prr_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              lock_set,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [REG_W-1:0]  rd_data,
    output logic              locked,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              acc_blocked,
    output logic              acc_err,
    output logic              acc_go
);
    typedef struct packed {
        logic blocked;
        logic err;
        logic go;
    } verdict_t;

    logic [NUM_RANGES-1:0][REG_W-1:0] regs;
    logic [NUM_RANGES-1:0]            hits;
    logic [PAGE_W-1:0]                page;
    logic                             deny;
    verdict_t                         vd_d, vd_q;

    prr_regs #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .lock_set  (lock_set),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_o    (regs),
        .locked_o  (locked)
    );

    assign page = acc_addr[PAGE_LSB +: PAGE_W];

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        prr_window u_win (
            .win      (decode_window(regs[g])),
            .page     (page),
            .is_write (acc_write),
            .hit      (hits[g])
        );
    end

    always_comb begin
        deny          = locked && (|hits);
        vd_d          = vd_q;
        vd_d.err      = acc_valid && deny;
        vd_d.go       = acc_valid && !deny;
        if (acc_valid)
            vd_d.blocked = deny;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign acc_blocked = vd_q.blocked;
    assign acc_err     = vd_q.err;
    assign acc_go      = vd_q.go;

    AST_ERR_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vd_q.err && vd_q.go)); // R9
    AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_q.err || vd_q.go) |-> $past(acc_valid)); // R9
    AST_ERR_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        vd_q.err |-> vd_q.blocked); // R9
    AST_OPEN_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !locked) |=> vd_q.go); // R5
endmodule

// File: tb/tb_prr_checker.sv
module tb_prr_checker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic        lock_set;
    logic [2:0]  rd_idx;
    logic [31:0] rd_data;
    logic        locked;
    logic        acc_valid;
    logic [24:0] acc_addr;
    logic        acc_write;
    logic        acc_blocked, acc_err, acc_go;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    prr_checker dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .lock_set(lock_set), .rd_idx(rd_idx),
        .rd_data(rd_data), .locked(locked), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_blocked(acc_blocked),
        .acc_err(acc_err), .acc_go(acc_go)
    );

    // {expect_blocked, write, addr[24:0]}
    localparam int NV = 15;
    localparam logic [26:0] VECS [NV] = '{
        27'h200FFFF, 27'h6010000, 27'h601FFFF, 27'h2020000, 27'h0010000,
        27'h4100000, 27'h4100FFF, 27'h0101000, 27'h2100000, 27'h5FFF000,
        27'h7FFFFFF, 27'h3FFE000, 27'h2045000, 27'h0050000, 27'h2040000
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] val, input logic lk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val; lock_set = lk;
        @(negedge clk);
        cfg_we = 1'b0; lock_set = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
        rd_idx = idx;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic access(input string req, input logic [24:0] a, input logic w, input logic exp_b);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " blocked"}, {31'b0, acc_blocked}, {31'b0, exp_b});
        check({req, " err"},     {31'b0, acc_err},     {31'b0, exp_b});
        check({req, " go"},      {31'b0, acc_go},      {31'b0, !exp_b});
        @(negedge clk);
        check("R9 err pulse ends", {31'b0, acc_err}, 32'd0);
        check("R9 go pulse ends",  {31'b0, acc_go},  32'd0);
        check("R9 level held",     {31'b0, acc_blocked}, {31'b0, exp_b});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; lock_set = 0;
        rd_idx = 0; acc_valid = 0; acc_addr = 0; acc_write = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 locked", {31'b0, locked}, 32'd0);
        check("R1 outputs", {29'b0, acc_blocked, acc_err, acc_go}, 32'd0);
        for (int i = 0; i < 5; i++) rd_chk("R1 reg zero", 3'(i), 32'd0);

        // R2 / R6 programming
        wr_reg(3'd0, 32'h801F_0010, 1'b0); // write-only window pages 0x010..0x01F
        wr_reg(3'd1, 32'h0100_8100, 1'b0); // read-only window page 0x100
        wr_reg(3'd2, 32'h9FFF_9FFF, 1'b0); // both, page 0x1FFF
        wr_reg(3'd3, 32'hE040_E050, 1'b0); // reserved bits set, lower > upper
        wr_reg(3'd5, 32'hFFFF_FFFF, 1'b0); // R3 out of range
        rd_chk("R2 reg0", 3'd0, 32'h801F_0010);
        rd_chk("R2 reg2", 3'd2, 32'h9FFF_9FFF);
        rd_chk("R2 reserved masked", 3'd3, 32'h8040_8050);
        rd_chk("R3 idx5 reads zero", 3'd5, 32'd0);
        rd_chk("R3 idx7 reads zero", 3'd7, 32'd0);
        rd_chk("R3 reg4 untouched", 3'd4, 32'd0);

        // R5 nothing blocked before lock
        access("R5 unlocked write", 25'h001_0000, 1'b1, 1'b0);
        access("R5 unlocked read",  25'h1FF_F000, 1'b0, 1'b0);

        // R11 write with lock in the same cycle
        wr_reg(3'd4, 32'h00FF_0000, 1'b1);
        check("R4 locked set", {31'b0, locked}, 32'd1);
        rd_chk("R11 reg4 stored", 3'd4, 32'h00FF_0000);

        // R4 writes ignored after lock
        wr_reg(3'd0, 32'h0000_0000, 1'b0);
        rd_chk("R4 reg0 frozen", 3'd0, 32'h801F_0010);
        wr_reg(3'd4, 32'h8000_8000, 1'b0);
        rd_chk("R4 reg4 frozen", 3'd4, 32'h00FF_0000);
        check("R4 lock sticky", {31'b0, locked}, 32'd1);

        // R6 R7 R8 R10 vector table
        for (int v = 0; v < NV; v++) begin
            access($sformatf("R7/R6/R8/R10 vec%0d", v), VECS[v][24:0], VECS[v][25], VECS[v][26]);
        end

        // R1 reset clears lock and registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 lock cleared", {31'b0, locked}, 32'd0);
        rd_chk("R1 reg0 cleared", 3'd0, 32'd0);
        access("R5 after reset", 25'h001_0000, 1'b1, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule